// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition flags of a small 8-bit processor core. There are four arithmetic flags: carry, half carry, zero and signed overflow. There are also two system flags: one records that the core entered its low-power halt state, and one records that the watchdog expired. Each cycle the core gives the block the operation class it is executing, with the operands and, for logic operations, the result. The block works out the arithmetic flags itself, using one internal adder that sees the same operands as the datapath. Each flag then updates by its own rule.

The status byte is a registered output, so any change shows on it one clock edge after the inputs that caused it. Software can overwrite the arithmetic flags through a 4-bit write port. The halt, watchdog-clear and watchdog-expiry strobes drive the two system flags. The synchronous reset acts as the power-up event. The operand width is a parameter. The half-carry boundary sits at the middle bit position.

Top module: `status_flag_reg`

## Requirements
- R1: status_o carries carry in bit 0, half carry in bit 1, zero in bit 2, overflow in bit 3, the halt flag in bit 4 and the time-out flag in bit 5. Bits 7:6 always read 0, and reset (power-up) clears the whole byte to 0x00.
- R2: op_i encodes 0 idle, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 logic, 6 rotate left through carry, 7 rotate right through carry. For codes 1 and 2, the block forms a_i + b_i + cin, where cin is 0 for add and the stored carry for add-with-carry. Carry becomes the carry out of the top bit.
- R3: For codes 3 and 4, the block forms a_i - b_i - bw, where bw is 0 for subtract and the inverse of the stored carry for subtract-with-borrow. Carry becomes 1 exactly when no borrow occurs, that is when a_i >= b_i + bw.
- R4: On the four arithmetic codes, half carry becomes the carry out of the low DW/2 bits for addition. For subtraction it becomes 1 exactly when the low DW/2 bits need no borrow.
- R5: Zero becomes 1 when the arithmetic result (modulo 2^DW) is 0 on codes 1 to 4, or when res_i is 0 on code 5. Otherwise it becomes 0.
- R6: On codes 1 to 4, overflow becomes 1 exactly when the two's-complement result falls outside the signed DW-bit range. This is the same as the carry into the top bit differing from the carry out of it.
- R7: A logic operation changes only the zero flag. Carry, half carry and overflow keep their values.
- R8: Rotate left loads carry from a_i[DW-1], and rotate right loads it from a_i[0]. Half carry, zero and overflow keep their values.
- R9: With op_i idle and no write, the arithmetic flags hold their values.
- R10: When wr_en_i is 1, bits 3:0 take wr_data_i and any operation in that cycle is ignored. Bits 5:4 cannot be written.
- R11: The halt flag is set by halt_i and cleared by clr_wdt_i. When both strobes arrive in the same cycle, the set wins.
- R12: The time-out flag is set by wdt_to_i and cleared by clr_wdt_i or halt_i. When a set and a clear arrive in the same cycle, the set wins.
- R13: Every update appears on status_o at the first rising clock edge after the inputs that cause it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acts as power-up |
| op_i | input | 3 | Operation class of the current instruction |
| a_i | input | DW | First operand; rotate source |
| b_i | input | DW | Second operand |
| res_i | input | DW | Result of a logic operation |
| wr_en_i | input | 1 | Software write of the arithmetic flags |
| wr_data_i | input | 4 | Value written to bits 3:0 |
| clr_wdt_i | input | 1 | Watchdog-clear instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| status_o | output | 8 | Registered status byte |

## Verification
Every flag lives only in a register that drives status_o directly. A wrong next-state value therefore shows on the port at the very next edge, with no path that could hide it. A stale carry is different: its effects can appear late. A carry that was written or rotated wrongly shows up only on a later add-with-carry or subtract-with-borrow. For that reason the sweeps preload carry through the write port and check both carry-in states for every operand pair. Stray updates are caught by checking the untouched flags after every logic, rotate, idle and event cycle. These are logic operations touching carry, or writes or events reaching the wrong half of the byte.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADC  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SBC  = 3'd4,
    OP_LOGIC = 3'd5,
    OP_RLC  = 3'd6,
    OP_RRC  = 3'd7
  } op_e;

  localparam int FL_C   = 0;
  localparam int FL_AC  = 1;
  localparam int FL_Z   = 2;
  localparam int FL_OV  = 3;
  localparam int FL_PDN = 4;
  localparam int FL_TMO = 5;
  localparam int ARITH_FLAGS = 4;
endpackage

// File: rtl/sflag_arith.sv
module sflag_arith
  import sflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c_stored,
  output logic          is_arith,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          hc_out,
  output logic          ov_out
);
  localparam int H  = DW / 2;
  localparam int MW = DW - 1 - H;

  if (DW < 4 || (DW % 2) != 0) begin : g_bad_width
    $error("sflag_arith: DW must be even and at least 4");
  end

  logic          is_sub;
  logic          cin;
  logic [DW-1:0] bx;
  logic [H:0]    s_lo;
  logic [MW:0]   s_mid;
  logic [1:0]    s_top;

  // One adder split at the half-carry point and below the top bit,
  // so both internal carries come out without a second adder.
  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBC);
    is_arith = (op == OP_ADD) || (op == OP_ADC) || is_sub;
    bx       = is_sub ? ~b : b;
    unique case (op)
      OP_ADC, OP_SBC: cin = c_stored;
      OP_SUB:         cin = 1'b1;
      default:        cin = 1'b0;
    endcase
    s_lo   = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, cin};
    s_mid  = {1'b0, a[DW-2:H]} + {1'b0, bx[DW-2:H]} + {{MW{1'b0}}, s_lo[H]};
    s_top  = {1'b0, a[DW-1]} + {1'b0, bx[DW-1]} + {1'b0, s_mid[MW]};
    sum    = {s_top[0], s_mid[MW-1:0], s_lo[H-1:0]};
    c_out  = s_top[1];
    hc_out = s_lo[H];
    ov_out = s_top[1] ^ s_mid[MW];
  end
endmodule

// File: rtl/sflag_sys.sv
module sflag_sys (
  input  logic clk,
  input  logic rst,
  input  logic clr_wdt,
  input  logic halt,
  input  logic wdt_to,
  output logic pdn_q,
  output logic tmo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pdn_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      if (halt)         pdn_q <= 1'b1;
      else if (clr_wdt) pdn_q <= 1'b0;
      if (wdt_to)               tmo_q <= 1'b1;
      else if (clr_wdt || halt) tmo_q <= 1'b0;
    end
  end

  p_halt_sets_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> pdn_q);
  p_clr_pdn_r11: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt && !halt) |=> !pdn_q);
  p_tmo_set_r12: assert property (@(posedge clk) disable iff (rst)
    wdt_to |=> tmo_q);
  p_tmo_clr_r12: assert property (@(posedge clk) disable iff (rst)
    ((clr_wdt || halt) && !wdt_to) |=> !tmo_q);
  p_sys_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!clr_wdt && !halt && !wdt_to) |=> ($stable(pdn_q) && $stable(tmo_q)));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_data_i,
  input  logic          clr_wdt_i,
  input  logic          halt_i,
  input  logic          wdt_to_i,
  output logic [7:0]    status_o
);
  op_e                   op;
  logic                  is_arith;
  logic [DW-1:0]         sum;
  logic                  c_add;
  logic                  hc_add;
  logic                  ov_add;
  logic [ARITH_FLAGS-1:0] af_q;
  logic [ARITH_FLAGS-1:0] af_d;
  logic                  pdn_q;
  logic                  tmo_q;

  assign op = op_e'(op_i);

  sflag_arith #(.DW(DW)) u_arith (
    .op       (op),
    .a        (a_i),
    .b        (b_i),
    .c_stored (af_q[FL_C]),
    .is_arith (is_arith),
    .sum      (sum),
    .c_out    (c_add),
    .hc_out   (hc_add),
    .ov_out   (ov_add)
  );

  sflag_sys u_sys (
    .clk     (clk),
    .rst     (rst),
    .clr_wdt (clr_wdt_i),
    .halt    (halt_i),
    .wdt_to  (wdt_to_i),
    .pdn_q   (pdn_q),
    .tmo_q   (tmo_q)
  );

  always_comb begin
    af_d = af_q;
    if (wr_en_i) begin
      af_d = wr_data_i;
    end else if (is_arith) begin
      af_d[FL_C]  = c_add;
      af_d[FL_AC] = hc_add;
      af_d[FL_Z]  = (sum == '0);
      af_d[FL_OV] = ov_add;
    end else begin
      unique case (op)
        OP_LOGIC: af_d[FL_Z] = (res_i == '0);
        OP_RLC:   af_d[FL_C] = a_i[DW-1];
        OP_RRC:   af_d[FL_C] = a_i[0];
        default:  af_d = af_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) af_q <= '0;
    else     af_q <= af_d;
  end

  assign status_o = {2'b00, tmo_q, pdn_q, af_q};

  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (status_o[3:0] == $past(wr_data_i)));
  p_logic_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && op_i == 3'd5) |=>
      ({status_o[FL_OV], status_o[FL_AC], status_o[FL_C]} ==
       $past({status_o[FL_OV], status_o[FL_AC], status_o[FL_C]})));
  p_rot_left_r8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && op_i == 3'd6) |=> (status_o[FL_C] == $past(a_i[DW-1])));
  p_rot_right_r8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && op_i == 3'd7) |=> (status_o[FL_C] == $past(a_i[0])));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && op_i == 3'd0) |=> $stable(status_o[3:0]));
  p_logic_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && op_i == 3'd5) |=> (status_o[FL_Z] == ($past(res_i) == '0)));
endmodule

// File: tb/sim_status_flag_reg.sv
module sim_status_flag_reg;
  localparam int BW = 4;
  localparam int N  = 1 << BW;
  localparam int Q  = 1 << (BW / 2);

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op_i;
  logic [BW-1:0] a_i, b_i, res_i;
  logic          wr_en_i;
  logic [3:0]    wr_data_i;
  logic          clr_wdt_i, halt_i, wdt_to_i;
  logic [7:0]    status_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  status_flag_reg #(.DW(BW)) u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_i(res_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .clr_wdt_i(clr_wdt_i),
    .halt_i(halt_i), .wdt_to_i(wdt_to_i), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    op_i = 3'd0; a_i = '0; b_i = '0; res_i = '0; wr_en_i = 1'b0;
    wr_data_i = '0; clr_wdt_i = 1'b0; halt_i = 1'b0; wdt_to_i = 1'b0;
  endtask

  // Inputs are set just after a falling edge; the next falling edge
  // follows the capturing rising edge, where outputs are sampled.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_write(input logic [3:0] d);
    wr_en_i = 1'b1; wr_data_i = d; step();
  endtask

  task automatic do_op(input int opc, input int a, input int b, input int r);
    op_i = 3'(opc); a_i = BW'(a); b_i = BW'(b); res_i = BW'(r); step();
  endtask

  function automatic int sgn(input int v);
    return (v >= N / 2) ? v - N : v;
  endfunction

  // Expected {ov,z,ac,c} from plain integer arithmetic.
  function automatic logic [3:0] model(input int opc, input int a, input int b, input int cf);
    int full, lo, sr, r, k;
    logic c, ac, z, ov;
    if (opc <= 2) begin
      k    = (opc == 2) ? cf : 0;
      full = a + b + k;
      c    = (full >= N);
      lo   = (a % Q) + (b % Q) + k;
      ac   = (lo >= Q);
      sr   = sgn(a) + sgn(b) + k;
      r    = full % N;
    end else begin
      k    = (opc == 4) ? 1 - cf : 0;
      full = a - b - k;
      c    = (full >= 0);
      lo   = (a % Q) - (b % Q) - k;
      ac   = (lo >= 0);
      sr   = sgn(a) - sgn(b) - k;
      r    = (full + 2 * N) % N;
    end
    ov = (sr > N / 2 - 1) || (sr < -(N / 2));
    z  = (r == 0);
    return {ov, z, ac, c};
  endfunction

  initial begin
    logic [3:0] e;
    logic [3:0] pre;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset value", status_o, 8'h00);

    // R13: output unchanged before the edge, updated after it.
    wr_en_i = 1'b1; wr_data_i = 4'h9;
    #1 chk("R13 before edge", status_o, 8'h00);
    step();
    chk("R13 after edge", status_o, 8'h09);

    // Exhaustive arithmetic sweep with both stored-carry states.
    for (int opc = 1; opc <= 4; opc++)
      for (int cf = 0; cf <= 1; cf++)
        for (int a = 0; a < N; a++)
          for (int b = 0; b < N; b++) begin
            do_write(4'(cf));
            do_op(opc, a, b, 0);
            e = model(opc, a, b, cf);
            if (opc <= 2) chk("R2 carry", {7'd0, status_o[0]}, {7'd0, e[0]});
            else          chk("R3 carry", {7'd0, status_o[0]}, {7'd0, e[0]});
            chk("R4 half carry", {7'd0, status_o[1]}, {7'd0, e[1]});
            chk("R5 zero", {7'd0, status_o[2]}, {7'd0, e[2]});
            chk("R6 overflow", {7'd0, status_o[3]}, {7'd0, e[3]});
          end

    // Logic: only zero moves.
    for (int p = 0; p <= 1; p++)
      for (int r = 0; r < N; r++) begin
        pre = (p == 1) ? 4'hF : 4'h0;
        do_write(pre);
        do_op(5, 15, 3, r);
        chk("R7 others kept", {4'd0, status_o[3], status_o[1:0], 1'b0},
            {4'd0, pre[3], pre[1:0], 1'b0});
        chk("R5 logic zero", {7'd0, status_o[2]}, {7'd0, (r == 0) ? 1'b1 : 1'b0});
      end

    // Rotates through carry.
    for (int dir = 6; dir <= 7; dir++)
      for (int p = 0; p <= 1; p++)
        for (int a = 0; a < N; a++) begin
          pre = (p == 1) ? 4'b1011 : 4'b0100;
          do_write(pre);
          do_op(dir, a, 0, 0);
          e = pre;
          e[0] = (dir == 6) ? a[BW-1] : a[0];
          chk("R8 rotate", {4'd0, status_o[3:0]}, {4'd0, e});
        end

    // Idle keeps the arithmetic flags.
    do_write(4'hA);
    for (int i = 0; i < 5; i++) begin
      do_op(0, 7, 9, 0);
      chk("R9 idle hold", status_o, 8'h0A);
    end

    // Write beats a concurrent add and never reaches bits 5:4.
    halt_i = 1'b1; step();
    wdt_to_i = 1'b1; step();
    for (int d = 0; d < 16; d++) begin
      wr_en_i = 1'b1; wr_data_i = 4'(d);
      op_i = 3'd1; a_i = BW'(N - 1); b_i = BW'(1);
      step();
      chk("R10 write", status_o, {4'b0011, 4'(d)});
      chk("R1 unused bits", {6'd0, status_o[7:6]}, 8'h00);
    end

    // System flag events from every start state.
    for (int s = 0; s < 4; s++)
      for (int ev = 0; ev < 8; ev++) begin
        logic pd0, to0, pd1, to1;
        pd0 = s[1]; to0 = s[0];
        clr_wdt_i = 1'b1; step();
        if (pd0) begin halt_i = 1'b1; step(); end
        if (to0) begin wdt_to_i = 1'b1; step(); end
        do_write(4'h5);
        clr_wdt_i = ev[0]; halt_i = ev[1]; wdt_to_i = ev[2];
        step();
        pd1 = ev[1] ? 1'b1 : (ev[0] ? 1'b0 : pd0);
        to1 = ev[2] ? 1'b1 : ((ev[0] || ev[1]) ? 1'b0 : to0);
        chk("R11 halt flag", {7'd0, status_o[4]}, {7'd0, pd1});
        chk("R12 time-out flag", {7'd0, status_o[5]}, {7'd0, to1});
        chk("R12 arith untouched", {4'd0, status_o[3:0]}, 8'h05);
      end

    // Power-up clears everything.
    halt_i = 1'b1; step();
    wdt_to_i = 1'b1; step();
    do_write(4'hF);
    rst = 1'b1; step();
    rst = 1'b0;
    chk("R1 reset clears", status_o, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R13 watchdog: actual hung, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule